// File: doc/BRIEF.md
# AXI Transaction ID Event Filter

This block sits beside a memory-controller performance counter bank and decides which AXI read and write transactions count toward the two ID-qualified events. Each observed transaction arrives as a one-cycle valid pulse with its 16-bit ID, a direction flag and a byte count. A single filter setting, shared by every counter, holds a reference ID and an ignore mask. A transaction qualifies when every ID bit that is not ignored equals the reference.

In its basic form the block emits a one-cycle read or write strobe per qualifying burst, and the counter bank counts those strobes. When the enhanced capability is built in and switched on, each counter whose event code selects the filtered read (0x41) or filtered write (0x42) event also accumulates the byte counts of the qualifying bursts. A byte-total read window returns these totals by counter index.

Top module: `axi_id_filter`

## Requirements
- R1: After reset both strobes are low and every byte total reads as zero. The stored reference ID and ignore mask reset to zero.
- R2: A valid read transaction whose ID matches raises `flt_rd_stb` for exactly the one cycle after it is presented. A transaction that does not match raises no strobe.
- R3: The upper half of `cfg_wdata` is the stored ignore mask and the lower half is the reference ID. A stored mask bit of 1 excludes that ID bit from the comparison, and a bit of 0 requires equality. With the mask all ones, every transaction matches.
- R4: A matching write (`txn_write`=1) raises only `flt_wr_stb`, and a matching read (`txn_write`=0) raises only `flt_rd_stb`. The two strobes are never high together.
- R5: A configuration write takes effect from the next cycle. A transaction presented in the same cycle as the write is compared against the previous setting.
- R6: With `ENHANCED`=1 and `enh_en`=1, counter n adds `txn_bytes` on each matching read when its code (`cnt_event[8n+7:8n]`) is 0x41, and on each matching write when its code is 0x42. The new total is visible one cycle after the transaction.
- R7: A counter whose code is neither 0x41 nor 0x42 never changes. No counter changes while `enh_en`=0, and no counter changes on a transaction that does not match.
- R8: `cnt_clear[n]` zeroes counter n on the next edge. It takes priority over an add in the same cycle and leaves the other counters untouched.
- R9: `rd_bytes` shows the total of counter `rd_sel`, and reads zero when `rd_sel` >= `NUM_CNT` or when the block is built with `ENHANCED`=0.
- R10: A cycle with `txn_valid` low produces no strobe in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the shared filter setting |
| cfg_wdata | input | 2*ID_W | {stored ignore mask, reference ID} |
| enh_en | input | 1 | Switches byte accumulation on |
| txn_valid | input | 1 | One-cycle transaction pulse |
| txn_write | input | 1 | 1 = write, 0 = read |
| txn_id | input | ID_W | Transaction ID |
| txn_bytes | input | BYTE_W | Bytes moved by the burst |
| cnt_event | input | 8*NUM_CNT | Event code per counter |
| cnt_clear | input | NUM_CNT | Per-counter clear of the byte total |
| rd_sel | input | SEL_W | Counter index for the byte-total window |
| rd_bytes | output | ACC_W | Byte total of the selected counter |
| flt_rd_stb | output | 1 | Qualifying read burst seen |
| flt_wr_stb | output | 1 | Qualifying write burst seen |

## Verification
The assertions assume that `txn_valid` pulses carry a defined direction and ID, and that the counter bank does not change a counter's event code in the same cycle as a transaction it wants counted. The stimulus presents every transaction for exactly one cycle, separated by idle cycles. It changes event codes and the configuration only on cycles without traffic, except in the deliberate same-cycle configuration case. Byte counts stay small enough that no total wraps, so the expected totals are plain sums.

// File: rtl/axf_pkg.sv
package axf_pkg;
    localparam int          EVT_W      = 8;
    localparam logic [7:0]  EVT_RD_FLT = 8'h41;
    localparam logic [7:0]  EVT_WR_FLT = 8'h42;
endpackage

// File: rtl/axf_match.sv
module axf_match #(
    parameter int ID_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2*ID_W-1:0] cfg_wdata,
    input  logic              txn_valid,
    input  logic              txn_write,
    input  logic [ID_W-1:0]   txn_id,
    output logic              hit,
    output logic              rd_stb,
    output logic              wr_stb
);
    typedef struct packed {
        logic [ID_W-1:0] ign;
        logic [ID_W-1:0] ref_id;
        logic            rd;
        logic            wr;
    } st_t;

    st_t st_d, st_q;
    logic id_ok;

    always_comb begin
        st_d  = st_q;
        id_ok = (((txn_id ^ st_q.ref_id) & ~st_q.ign) == '0);
        hit   = txn_valid && id_ok;
        if (cfg_we) begin
            st_d.ign    = cfg_wdata[2*ID_W-1:ID_W];
            st_d.ref_id = cfg_wdata[ID_W-1:0];
        end
        st_d.rd = hit && !txn_write;
        st_d.wr = hit &&  txn_write;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_stb = st_q.rd;
    assign wr_stb = st_q.wr;

    AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_stb && wr_stb)); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !txn_valid |=> (!rd_stb && !wr_stb)); // R10
    AST_ALL_IGNORED_HITS: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && !txn_write && (&st_q.ign)) |=> rd_stb); // R3
endmodule

// File: rtl/axf_accum.sv
module axf_accum #(
    parameter int BYTE_W = 8,
    parameter int ACC_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              add,
    input  logic [BYTE_W-1:0] bytes,
    output logic [ACC_W-1:0]  total
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear)    st_d.acc = '0;
        else if (add) st_d.acc = st_q.acc + ACC_W'(bytes);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign total = st_q.acc;

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (total == '0)); // R8
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !add) |=> $stable(total)); // R7
endmodule

// File: rtl/axi_id_filter.sv
module axi_id_filter
    import axf_pkg::*;
#(
    parameter int NUM_CNT  = 3,
    parameter int ID_W     = 16,
    parameter int BYTE_W   = 8,
    parameter int ACC_W    = 32,
    parameter bit ENHANCED = 1'b1,
    localparam int SEL_W   = $clog2(NUM_CNT + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [2*ID_W-1:0]        cfg_wdata,
    input  logic                     enh_en,
    input  logic                     txn_valid,
    input  logic                     txn_write,
    input  logic [ID_W-1:0]          txn_id,
    input  logic [BYTE_W-1:0]        txn_bytes,
    input  logic [EVT_W*NUM_CNT-1:0] cnt_event,
    input  logic [NUM_CNT-1:0]       cnt_clear,
    input  logic [SEL_W-1:0]         rd_sel,
    output logic [ACC_W-1:0]         rd_bytes,
    output logic                     flt_rd_stb,
    output logic                     flt_wr_stb
);
    logic             hit;
    logic [ACC_W-1:0] totals [NUM_CNT];

    axf_match #(.ID_W(ID_W)) i_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .txn_valid (txn_valid),
        .txn_write (txn_write),
        .txn_id    (txn_id),
        .hit       (hit),
        .rd_stb    (flt_rd_stb),
        .wr_stb    (flt_wr_stb)
    );

    for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
        if (ENHANCED) begin : g_enh
            logic [EVT_W-1:0] code;
            logic             add_d;
            assign code  = cnt_event[n*EVT_W +: EVT_W];
            assign add_d = enh_en && hit &&
                           ((code == EVT_RD_FLT && !txn_write) ||
                            (code == EVT_WR_FLT &&  txn_write));
            axf_accum #(.BYTE_W(BYTE_W), .ACC_W(ACC_W)) i_accum (
                .clk   (clk),
                .rst_n (rst_n),
                .clear (cnt_clear[n]),
                .add   (add_d),
                .bytes (txn_bytes),
                .total (totals[n])
            );
        end else begin : g_basic
            assign totals[n] = '0;
        end
    end

    always_comb begin
        rd_bytes = '0;
        for (int n = 0; n < NUM_CNT; n++) begin
            if (rd_sel == SEL_W'(n)) rd_bytes = totals[n];
        end
    end

    AST_WINDOW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rd_sel) >= NUM_CNT) |-> (rd_bytes == '0)); // R9
endmodule

// File: tb/test_axi_id_filter.sv
`timescale 1ns/100ps
module test_axi_id_filter;
    localparam int NUM_CNT = 3;
    localparam int ID_W    = 16;
    localparam int BYTE_W  = 8;
    localparam int ACC_W   = 32;
    localparam int SEL_W   = 2;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 cfg_we = 1'b0;
    logic [2*ID_W-1:0]    cfg_wdata = '0;
    logic                 enh_en = 1'b0;
    logic                 txn_valid = 1'b0;
    logic                 txn_write = 1'b0;
    logic [ID_W-1:0]      txn_id = '0;
    logic [BYTE_W-1:0]    txn_bytes = '0;
    logic [8*NUM_CNT-1:0] cnt_event = '0;
    logic [NUM_CNT-1:0]   cnt_clear = '0;
    logic [SEL_W-1:0]     rd_sel = '0;
    logic [ACC_W-1:0]     rd_bytes, rd_bytes_b;
    logic                 flt_rd_stb, flt_wr_stb, rd_stb_b, wr_stb_b;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;
    int exp_acc [NUM_CNT];

    always #2.5 clk = ~clk;

    axi_id_filter #(.NUM_CNT(NUM_CNT), .ID_W(ID_W), .BYTE_W(BYTE_W),
                    .ACC_W(ACC_W), .ENHANCED(1'b1)) i_axi_id_filter (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .enh_en(enh_en), .txn_valid(txn_valid), .txn_write(txn_write),
        .txn_id(txn_id), .txn_bytes(txn_bytes), .cnt_event(cnt_event),
        .cnt_clear(cnt_clear), .rd_sel(rd_sel), .rd_bytes(rd_bytes),
        .flt_rd_stb(flt_rd_stb), .flt_wr_stb(flt_wr_stb));

    axi_id_filter #(.NUM_CNT(NUM_CNT), .ID_W(ID_W), .BYTE_W(BYTE_W),
                    .ACC_W(ACC_W), .ENHANCED(1'b0)) i_axi_id_filter_basic (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .enh_en(enh_en), .txn_valid(txn_valid), .txn_write(txn_write),
        .txn_id(txn_id), .txn_bytes(txn_bytes), .cnt_event(cnt_event),
        .cnt_clear(cnt_clear), .rd_sel(rd_sel), .rd_bytes(rd_bytes_b),
        .flt_rd_stb(rd_stb_b), .flt_wr_stb(wr_stb_b));

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic set_cfg(logic [15:0] id, logic [15:0] ign);
        cfg_we = 1'b1; cfg_wdata = {ign, id};
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // present one transaction; check the strobes in the cycle after it
    task automatic txn(string req, bit wr, logic [15:0] id, logic [7:0] nb, bit exp_hit);
        txn_valid = 1'b1; txn_write = wr; txn_id = id; txn_bytes = nb;
        @(negedge clk);
        txn_valid = 1'b0;
        check(req, {30'd0, flt_wr_stb, flt_rd_stb}, {30'd0, exp_hit && wr, exp_hit && !wr});
        check(req, {30'd0, wr_stb_b, rd_stb_b}, {30'd0, exp_hit && wr, exp_hit && !wr});
        @(negedge clk);
    endtask

    task automatic check_totals(string req);
        for (int n = 0; n < NUM_CNT; n++) begin
            rd_sel = SEL_W'(n);
            #0.5;
            check(req, rd_bytes, exp_acc[n]);
            check("R9 basic build reads zero", rd_bytes_b, 32'd0);
        end
        rd_sel = 2'd3;
        #0.5;
        check("R9 out-of-range index", rd_bytes, 32'd0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 strobes after reset", {30'd0, flt_wr_stb, flt_rd_stb}, 32'd0);
        check_totals("R1 totals after reset");
    endtask

    task automatic t_basic_match();
        set_cfg(16'h1234, 16'h0000);
        txn("R2 exact read match", 1'b0, 16'h1234, 8'd4, 1'b1);
        txn("R2 one-bit mismatch", 1'b0, 16'h1235, 8'd4, 1'b0);
        txn("R4 write match", 1'b1, 16'h1234, 8'd4, 1'b1);
    endtask

    task automatic t_idle();
        @(negedge clk);
        check("R10 no strobe when idle", {30'd0, flt_wr_stb, flt_rd_stb}, 32'd0);
    endtask

    task automatic t_mask();
        set_cfg(16'h1200, 16'h00FF);
        txn("R3 ignored low byte", 1'b0, 16'h12AB, 8'd1, 1'b1);
        txn("R3 compared high byte", 1'b0, 16'h13AB, 8'd1, 1'b0);
        set_cfg(16'h0000, 16'hFFFF);
        txn("R3 all ignored", 1'b0, 16'hBEEF, 8'd1, 1'b1);
        check_totals("R7 no bytes while enh_en=0");
    endtask

    task automatic t_cfg_timing();
        set_cfg(16'h0010, 16'h0000);
        // write a new ID in the same cycle as a transaction using that new ID
        cfg_we = 1'b1; cfg_wdata = {16'h0000, 16'h0020};
        txn("R5 same-cycle uses old setting", 1'b0, 16'h0020, 8'd1, 1'b0);
        cfg_we = 1'b0;
        txn("R5 next cycle uses new setting", 1'b0, 16'h0020, 8'd1, 1'b1);
    endtask

    task automatic t_enhanced();
        cnt_event = {8'h42, 8'h41, 8'h00};
        enh_en = 1'b1;
        set_cfg(16'h0040, 16'h000F);
        txn("R6 matched read", 1'b0, 16'h0045, 8'd64, 1'b1);  exp_acc[1] += 64;
        txn("R6 matched write", 1'b1, 16'h004A, 8'd16, 1'b1); exp_acc[2] += 16;
        txn("R7 unmatched read", 1'b0, 16'h0145, 8'd8, 1'b0);
        txn("R6 second read", 1'b0, 16'h004F, 8'd200, 1'b1); exp_acc[1] += 200;
        check_totals("R6 R7 byte totals");
    endtask

    task automatic t_clear();
        cnt_clear = 3'b010;
        txn("R8 clear beats add", 1'b0, 16'h0041, 8'd32, 1'b1);
        cnt_clear = '0;
        exp_acc[1] = 0;
        check_totals("R8 totals after clear");
        cnt_event = {8'h42, 8'h41, 8'h42};
        txn("R6 recoded counter", 1'b1, 16'h0040, 8'd5, 1'b1);
        exp_acc[0] += 5; exp_acc[2] += 5;
        check_totals("R6 shared filter on two counters");
        enh_en = 1'b0;
        txn("R7 enh_en off", 1'b0, 16'h0040, 8'd9, 1'b1);
        check_totals("R7 no add with enh_en=0");
    endtask

    initial begin
        for (int n = 0; n < NUM_CNT; n++) exp_acc[n] = 0;
        t_reset();
        t_basic_match();
        t_idle();
        t_mask();
        t_cfg_timing();
        t_enhanced();
        t_clear();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule